// File: doc/BRIEF.md
# Hotplug Slot Event Controller

This block keeps the hotplug register state of one downstream port of a PCIe hierarchy. It holds the slot capability word, the slot control enables, the slot status change and presence bits, the link-active flag and the MSI enable bit. A management agent signals device insertion and removal with single-cycle strobes. Each strobe updates presence, link state and both change flags together in one clock edge.

Configuration software reaches the registers through a dword port. The port has byte enables and a combinational read path. The change flags are write-one-to-clear. Presence and link state are read-only. Control writes act at once, and command completion is never reported, so software never waits on a slot command.

The block raises a one-cycle MSI request when three things hold together: MSI is enabled, hotplug interrupts are enabled, and a change flag whose own source enable is set is pending. A request is never lost. An event that arrives while interrupts are masked is signalled once the masks open. Built with hotplug off, the port ignores the strobes and keeps the slot state it had at reset.

Top module: `hp_slot_ctrl`

## Requirements
- R1: An insertion strobe sets the presence bit (status bit 6), the presence-changed bit (status bit 0), the link-changed bit (status bit 1) and the link-up bit (link register bit 0). All four are visible after the same clock edge. If both strobes are high together, insertion wins.
- R2: A removal strobe clears presence and link-up and sets both change bits, all after the same clock edge.
- R3: Status bits 0 and 1 are write-one-to-clear. Writing 0 leaves them unchanged. A write whose byte enable 0 is low has no effect.
- R4: If an insertion or removal and a write-one-to-clear hit the same change bit in the same cycle, the bit ends up set.
- R5: Config writes never change the presence bit or the link-up bit.
- R6: The capability register (offset 0) reads bit 0 = hotplug capable, bit 1 = 1 (no command-completed support) and bits 31:24 = slot number. The command-completed status bit (status bit 3) always reads 0.
- R7: Control register writes (offset 1; bit 0 presence-changed enable, bit 1 link-changed enable, bit 5 hotplug interrupt enable) read back after the write edge and steer the MSI in the next cycle. Undefined bits read 0.
- R8: msi_req_o pulses high for exactly one cycle each time the interrupt condition becomes true. The condition is MSI enable (offset 4 bit 0) AND hotplug interrupt enable AND (presence-changed with its enable OR link-changed with its enable).
- R9: A change bit set while interrupts are masked is kept. Opening the hotplug enable or the MSI enable later gives one pulse.
- R10: With HOTPLUG_EN = 0, the strobes have no effect, and presence and link-up stay at their reset value STATIC_PRESENT.
- R11: After reset, a hotplug port reads all status, link, control and MSI enable bits as 0, and msi_req_o is 0.
- R12: A pending change bit whose own source enable is clear does not keep the interrupt condition true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hp_add_i | input | 1 | Device insertion strobe |
| hp_remove_i | input | 1 | Device removal strobe |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | AW | Dword register index |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i (combinational) |
| msi_req_o | output | 1 | One-cycle MSI request |

## Verification
The assertions check four things on every cycle:
- the combined update that each strobe makes;
- that a change bit is set after a collision between an event and a clear;
- that slot state stays frozen on a port built without hotplug;
- that the MSI request lasts one cycle and never fires while either enable is off.

Other behaviour shows up only in sequences, so the bench scenarios must cover it. This includes a late-enabled interrupt that picks up an old event, a per-source mask that drops the condition, writes gated by byte enables, and ignored writes to presence and link.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int OFF_CAP  = 0;
  localparam int OFF_CTRL = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_LINK = 3;
  localparam int OFF_MSI  = 4;

  localparam int CTL_PCE  = 0;
  localparam int CTL_LCE  = 1;
  localparam int CTL_HIE  = 5;
  localparam int ST_PC    = 0;
  localparam int ST_LC    = 1;
  localparam int ST_CC    = 3;
  localparam int ST_PRES  = 6;
  localparam int LNK_UP   = 0;
  localparam int MSI_EN   = 0;
  localparam int CAP_HP   = 0;
  localparam int CAP_NCC  = 1;

  typedef struct packed {
    logic pres_chg_en;
    logic link_chg_en;
    logic hp_irq_en;
  } slot_ctl_t;

  typedef struct packed {
    logic present;
    logic link_up;
    logic pres_chg;
    logic link_chg;
  } slot_st_t;
endpackage

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_slot_pkg::*;
#(
  parameter bit HOTPLUG_EN     = 1'b1,
  parameter bit STATIC_PRESENT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     add_i,
  input  logic     remove_i,
  input  logic     clr_pc_i,
  input  logic     clr_lc_i,
  output slot_st_t st_o
);
  localparam logic RST_PRES = HOTPLUG_EN ? 1'b0 : STATIC_PRESENT;

  logic     ev;
  slot_st_t st_q;

  assign ev = HOTPLUG_EN && (add_i || remove_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.present  <= RST_PRES;
      st_q.link_up  <= RST_PRES;
      st_q.pres_chg <= 1'b0;
      st_q.link_chg <= 1'b0;
    end else begin
      if (HOTPLUG_EN && add_i) begin
        st_q.present <= 1'b1;
        st_q.link_up <= 1'b1;
      end else if (HOTPLUG_EN && remove_i) begin
        st_q.present <= 1'b0;
        st_q.link_up <= 1'b0;
      end
      // event set beats a simultaneous clear
      st_q.pres_chg <= ev || (st_q.pres_chg && !clr_pc_i);
      st_q.link_chg <= ev || (st_q.link_chg && !clr_lc_i);
    end
  end

  assign st_o = st_q;

  generate
    if (HOTPLUG_EN) begin : g_hp_chk
      a_r1_add_atomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
        add_i |=> (st_o.present && st_o.link_up && st_o.pres_chg && st_o.link_chg));
      a_r2_remove_atomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (remove_i && !add_i) |=> (!st_o.present && !st_o.link_up && st_o.pres_chg && st_o.link_chg));
      a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((add_i || remove_i) && clr_pc_i) |=> st_o.pres_chg);
    end else begin : g_fixed_chk
      a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($stable(st_o.present) && $stable(st_o.link_up) && !st_o.pres_chg));
    end
  endgenerate
endmodule

// File: rtl/hp_cfg_regs.sv
module hp_cfg_regs
  import hp_slot_pkg::*;
#(
  parameter int       AW         = 3,
  parameter bit       HOTPLUG_EN = 1'b1,
  parameter bit [7:0] SLOT_NUM   = 8'h2A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  slot_st_t      st_i,
  output slot_ctl_t     ctl_o,
  output logic          msi_en_o,
  output logic          clr_pc_o,
  output logic          clr_lc_o,
  output logic [31:0]   rdata_o
);
  localparam logic [AW-1:0] A_CAP  = AW'(OFF_CAP);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_LINK = AW'(OFF_LINK);
  localparam logic [AW-1:0] A_MSI  = AW'(OFF_MSI);

  logic      wr_b0;
  slot_ctl_t ctl_q;
  logic      msi_en_q;
  logic      unused_wr;

  assign wr_b0     = we_i && be_i[0];
  assign unused_wr = ^{wdata_i[31:8], be_i[3:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      msi_en_q <= 1'b0;
    end else if (wr_b0) begin
      if (addr_i == A_CTRL) begin
        ctl_q.pres_chg_en <= wdata_i[CTL_PCE];
        ctl_q.link_chg_en <= wdata_i[CTL_LCE];
        ctl_q.hp_irq_en   <= wdata_i[CTL_HIE];
      end
      if (addr_i == A_MSI) msi_en_q <= wdata_i[MSI_EN];
    end
  end

  assign clr_pc_o = wr_b0 && (addr_i == A_STAT) && wdata_i[ST_PC];
  assign clr_lc_o = wr_b0 && (addr_i == A_STAT) && wdata_i[ST_LC];
  assign ctl_o    = ctl_q;
  assign msi_en_o = msi_en_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CAP: begin
        rdata_o[CAP_HP]  = HOTPLUG_EN;
        rdata_o[CAP_NCC] = 1'b1;
        rdata_o[31:24]   = SLOT_NUM;
      end
      A_CTRL: begin
        rdata_o[CTL_PCE] = ctl_q.pres_chg_en;
        rdata_o[CTL_LCE] = ctl_q.link_chg_en;
        rdata_o[CTL_HIE] = ctl_q.hp_irq_en;
      end
      A_STAT: begin
        rdata_o[ST_PC]   = st_i.pres_chg;
        rdata_o[ST_LC]   = st_i.link_chg;
        rdata_o[ST_CC]   = 1'b0;
        rdata_o[ST_PRES] = st_i.present;
      end
      A_LINK: rdata_o[LNK_UP] = st_i.link_up;
      A_MSI:  rdata_o[MSI_EN] = msi_en_q;
      default: rdata_o = '0;
    endcase
  end

  a_r7_ctl_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b0 && addr_i == A_CTRL) |=> (ctl_o.hp_irq_en == $past(wdata_i[CTL_HIE])));
  a_r3_be_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!be_i[0]) |=> ($stable(ctl_o) && $stable(msi_en_o)));
endmodule

// File: rtl/hp_msi_gen.sv
module hp_msi_gen
  import hp_slot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  slot_ctl_t ctl_i,
  input  logic      msi_en_i,
  input  logic      pres_chg_i,
  input  logic      link_chg_i,
  output logic      msi_o
);
  logic src_hit;
  logic cond;
  logic cond_q;

  assign src_hit = (pres_chg_i && ctl_i.pres_chg_en) || (link_chg_i && ctl_i.link_chg_en);
  assign cond    = msi_en_i && ctl_i.hp_irq_en && src_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond;
  end

  // edge of the level condition: late enables still fire once
  assign msi_o = cond && !cond_q;

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |=> !msi_o);
  a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |-> (msi_en_i && ctl_i.hp_irq_en));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int       AW             = 3,
  parameter bit       HOTPLUG_EN     = 1'b1,
  parameter bit       STATIC_PRESENT = 1'b1,
  parameter bit [7:0] SLOT_NUM       = 8'h2A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hp_add_i,
  input  logic          hp_remove_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [3:0]    cfg_be_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  output logic          msi_req_o
);
  slot_st_t  st;
  slot_ctl_t ctl;
  logic      msi_en;
  logic      clr_pc;
  logic      clr_lc;

  hp_slot_state #(
    .HOTPLUG_EN    (HOTPLUG_EN),
    .STATIC_PRESENT(STATIC_PRESENT)
  ) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .add_i   (hp_add_i),
    .remove_i(hp_remove_i),
    .clr_pc_i(clr_pc),
    .clr_lc_i(clr_lc),
    .st_o    (st)
  );

  hp_cfg_regs #(
    .AW        (AW),
    .HOTPLUG_EN(HOTPLUG_EN),
    .SLOT_NUM  (SLOT_NUM)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .st_i    (st),
    .ctl_o   (ctl),
    .msi_en_o(msi_en),
    .clr_pc_o(clr_pc),
    .clr_lc_o(clr_lc),
    .rdata_o (cfg_rdata_o)
  );

  hp_msi_gen u_msi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl),
    .msi_en_i  (msi_en),
    .pres_chg_i(st.pres_chg),
    .link_chg_i(st.link_chg),
    .msi_o     (msi_req_o)
  );
endmodule

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int AW = 3;
  localparam int NV = 26;

  typedef struct packed {
    logic       add;
    logic       rem;
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [3:0] be;
    logic [7:0] stat;
    logic       link;
    logic       msi;
  } vec_t;

  // addr: 1 ctrl, 2 status, 3 link, 4 msi
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,3'd1,8'h23,4'h1,8'h00,1'b0,1'b0}, // R7 ctrl, msi off
    '{1'b0,1'b0,1'b1,3'd4,8'h01,4'h1,8'h00,1'b0,1'b0}, // msi on, nothing pending
    '{1'b1,1'b0,1'b0,3'd0,8'h00,4'h0,8'h43,1'b1,1'b1}, // R1 add
    '{1'b0,1'b0,1'b0,3'd0,8'h00,4'h0,8'h43,1'b1,1'b0}, // R8 one cycle
    '{1'b0,1'b0,1'b1,3'd2,8'h01,4'h1,8'h42,1'b1,1'b0}, // R3 clear pc
    '{1'b0,1'b0,1'b1,3'd2,8'h02,4'h1,8'h40,1'b1,1'b0}, // R3 clear lc
    '{1'b0,1'b0,1'b1,3'd2,8'h40,4'h1,8'h40,1'b1,1'b0}, // R5 presence RO
    '{1'b0,1'b0,1'b1,3'd3,8'h00,4'h1,8'h40,1'b1,1'b0}, // R5 link RO
    '{1'b0,1'b1,1'b0,3'd0,8'h00,4'h0,8'h03,1'b0,1'b1}, // R2 remove
    '{1'b0,1'b0,1'b1,3'd2,8'h03,4'h0,8'h03,1'b0,1'b0}, // R3 be low
    '{1'b0,1'b0,1'b1,3'd2,8'h03,4'h1,8'h00,1'b0,1'b0}, // R3 clear both
    '{1'b0,1'b0,1'b1,3'd1,8'h00,4'h1,8'h00,1'b0,1'b0}, // mask hp irq
    '{1'b1,1'b0,1'b0,3'd0,8'h00,4'h0,8'h43,1'b1,1'b0}, // R9 masked add
    '{1'b0,1'b0,1'b1,3'd1,8'h23,4'h1,8'h43,1'b1,1'b1}, // R9 late enable
    '{1'b0,1'b0,1'b1,3'd2,8'h03,4'h1,8'h40,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,3'd2,8'h01,4'h1,8'h43,1'b1,1'b1}, // R4 set wins
    '{1'b0,1'b0,1'b1,3'd2,8'h03,4'h1,8'h40,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,3'd1,8'h22,4'h1,8'h40,1'b1,1'b0}, // link src only
    '{1'b0,1'b1,1'b0,3'd0,8'h00,4'h0,8'h03,1'b0,1'b1}, // R2 remove
    '{1'b0,1'b0,1'b1,3'd2,8'h02,4'h1,8'h01,1'b0,1'b0}, // R12 pc masked
    '{1'b0,1'b0,1'b1,3'd1,8'h23,4'h1,8'h01,1'b0,1'b1}, // R12 pc enabled
    '{1'b0,1'b0,1'b1,3'd4,8'h00,4'h1,8'h01,1'b0,1'b0}, // msi off
    '{1'b0,1'b0,1'b1,3'd2,8'h01,4'h1,8'h00,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,3'd0,8'h00,4'h0,8'h43,1'b1,1'b0}, // R9 add, msi off
    '{1'b0,1'b0,1'b1,3'd4,8'h01,4'h1,8'h43,1'b1,1'b1}, // R9 msi enable
    '{1'b0,1'b0,1'b1,3'd1,8'h23,4'h1,8'h43,1'b1,1'b0}  // R6 no cc, R8
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          add = 1'b0, rem = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_fx;
  logic          msi, msi_fx;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  hp_slot_ctrl #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hp_add_i(add), .hp_remove_i(rem),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .msi_req_o(msi));

  hp_slot_ctrl #(.AW(AW), .HOTPLUG_EN(1'b0)) uut_fixed (
    .clk_i(clk), .rst_ni(rst_n), .hp_add_i(add), .hp_remove_i(rem),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata_fx), .msi_req_o(msi_fx));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v, output logic [31:0] vf);
    addr = AW'(a);
    #1;
    v  = rdata;
    vf = rdata_fx;
  endtask

  task automatic idle_inputs();
    add = 1'b0; rem = 1'b0; we = 1'b0; be = '0; wdata = '0;
  endtask

  initial begin
    logic [31:0] v, vf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R6 capability
    rd(0, v, vf); chg: begin end
    chk("R6 cap", v, 32'h2A00_0003);
    chk("R10 fixed cap", vf, 32'h2A00_0002);
    rd(1, v, vf); chk("R11 ctrl", v, 32'h0);
    rd(2, v, vf); chk("R11 status", v, 32'h0);
    chk("R10 fixed status", vf, 32'h40);
    rd(3, v, vf); chk("R11 link", v, 32'h0);
    chk("R10 fixed link", vf, 32'h1);
    rd(4, v, vf); chk("R11 msi en", v, 32'h0);
    chk("R11 msi", {31'b0, msi}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      add = VEC[i].add; rem = VEC[i].rem; we = VEC[i].we;
      addr = VEC[i].addr; wdata = {24'b0, VEC[i].wdata}; be = VEC[i].be;
      @(negedge clk);
      idle_inputs();
      rd(2, v, vf);
      chk($sformatf("R1/R2/R3/R4/R5/R6 status vec %0d", i), v, {24'b0, VEC[i].stat});
      rd(3, v, vf);
      chk($sformatf("R1/R2/R5 link vec %0d", i), v, {31'b0, VEC[i].link});
      chk($sformatf("R8/R9/R12 msi vec %0d", i), {31'b0, msi}, {31'b0, VEC[i].msi});
    end

    // R7 undefined ctrl bits read 0
    we = 1'b1; addr = 3'd1; be = 4'h1; wdata = 32'hFF;
    @(negedge clk); idle_inputs();
    rd(1, v, vf); chk("R7 ctrl readback", v, 32'h23);

    // R10 fixed port ignores strobes
    rem = 1'b1;
    @(negedge clk); idle_inputs();
    rd(2, v, vf); chk("R10 fixed status after remove", vf, 32'h40);
    rd(3, v, vf); chk("R10 fixed link after remove", vf, 32'h1);
    chk("R10 fixed msi", {31'b0, msi_fx}, 32'h0);
    add = 1'b1;
    @(negedge clk); idle_inputs();
    rd(2, v, vf); chk("R10 fixed status after add", vf, 32'h40);

    // R1 both strobes: add wins
    add = 1'b1; rem = 1'b1;
    @(negedge clk); idle_inputs();
    rd(3, v, vf); chk("R1 add over remove", v, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule